// File: doc/BRIEF.md
# Alignment Marker Request Timer

This block generates the periodic alignment-marker request that fabric logic presents alongside each word of a 66-bit PCS transmit stream when a forward-error-correction or fixed-timing flexible-Ethernet mode needs markers at an exact cadence. The transmit valid qualifier decides time for the block. Only clock cycles that carry valid data are counted. On a cycle without valid data the period counter and the request both hold.

Start-up waits for two things. The transmit PLL must report lock, and the PCS ready input must show at least one transition after lock. Once running, the timer repeats its period until reset or loss of lock. Each period opens with the request high for a fixed number of valid cycles. The period is chosen at run time between a full hardware length and a shortened simulation length. The simulation length depends on whether the build carries timestamping. When FEC support is compiled out, the request never rises.

Top module: `amReqTimer`

## Requirements
- R1: While `rst` is high, or on the cycle after any cycle with `pllLocked` low, `amReq` is 0. Both conditions clear the started state, so a later start needs a fresh ready transition after lock returns.
- R2: `amReq` stays 0 until `pcsReady` has changed value between two consecutive cycles during which `pllLocked` was high. Running begins on the first valid cycle on or after that transition.
- R3: Each period begins with `amReq` high for exactly HIGH_CYCLES valid cycles, which is 4 by default. It is then low for the rest of the period.
- R4: Successive rising edges of `amReq` are separated by exactly one period counted in valid cycles, whatever pattern of valid-low gaps lies between them.
- R5: Across any clock edge that closes a cycle with `txValid` low (and `pllLocked` high, `rst` low), `amReq` and the period position do not change.
- R6: With `simMode` 1 the period is SIM_PERIOD (2552) in a build without timestamping and SIM_PERIOD_TS (5112) with TS_BUILD=1. With `simMode` 0 it is HW_PERIOD (81920).
- R7: With FEC_ENABLE=0, `amReq` is 0 at all times.
- R8: Once started, the timer keeps running when `pcsReady` stops changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock |
| rst | input | 1 | Synchronous reset, active high |
| pllLocked | input | 1 | Transmit PLL lock indication |
| pcsReady | input | 1 | PCS ready indication; a transition after lock enables start |
| txValid | input | 1 | Transmit data valid; only these cycles advance the period |
| simMode | input | 1 | 1 selects the shortened simulation period, 0 the hardware period |
| amReq | output | 1 | Alignment-marker insertion request for the current cycle |

## Verification
The bench first drives an unbroken valid stream. This shows the plain period and high time with no freezing involved. It then applies random valid-low gaps, which separate counting in valid cycles from counting in raw clocks, because a timer that counts clocks would place its rising edges early. Ready toggling without lock, followed by lock with a steady ready, tells the lock gate apart from the ready-activity gate. Dropping lock or reset mid-period, then bringing lock back with a quiet ready, shows that the started state is truly cleared. A second instance built with timestamping and a third with FEC disabled check the period choice and the permanently low request.

// File: rtl/amReqTimerPkg.sv
package amReqTimerPkg;

  // Commands from control to the period counter; at most one is active per cycle.
  typedef struct packed {
    logic clear;    // return to idle position
    logic load;     // first valid cycle of a run: position zero
    logic advance;  // step to next position within the period
    logic wrap;     // last position reached: start the next period
  } cntCmd_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/amReqCtrl.sv
module amReqCtrl
  import amReqTimerPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pllLocked,
  input  logic    pcsReady,
  input  logic    txValid,
  input  logic    periodEnd,
  output cntCmd_t cmd,
  output logic    running
);

  logic readyPrev;
  logic lockPrev;
  logic armed;
  logic readyEdge;
  logic goClear;
  logic mayStart;

  // A ready transition counts only if lock held on both sides of it.
  assign readyEdge = pllLocked & lockPrev & (pcsReady ^ readyPrev);
  assign goClear   = rst | ~pllLocked;
  assign mayStart  = armed | readyEdge;

  always_ff @(posedge clk) begin
    if (rst) begin
      readyPrev <= 1'b0;
      lockPrev  <= 1'b0;
    end else begin
      readyPrev <= pcsReady;
      lockPrev  <= pllLocked;
    end
  end

  always_ff @(posedge clk) begin
    if (goClear) begin
      armed   <= 1'b0;
      running <= 1'b0;
    end else begin
      if (readyEdge) armed <= 1'b1;
      if (txValid && !running && mayStart) running <= 1'b1;
    end
  end

  always_comb begin
    cmd         = '0;
    cmd.clear   = goClear;
    cmd.load    = !goClear && txValid && !running && mayStart;
    cmd.advance = !goClear && txValid && running && !periodEnd;
    cmd.wrap    = !goClear && txValid && running && periodEnd;
  end

endmodule

// File: rtl/amReqCount.sv
module amReqCount
  import amReqTimerPkg::*;
#(
  parameter int HW_PERIOD     = 81920,
  parameter int SIM_PERIOD    = 2552,
  parameter int SIM_PERIOD_TS = 5112,
  parameter int TS_BUILD      = 0,
  parameter int HIGH_CYCLES   = 4
) (
  input  logic    clk,
  input  cntCmd_t cmd,
  input  logic    simMode,
  output logic    periodEnd,
  output logic    inHigh
);

  localparam int MAX_LEN = maxOf3(HW_PERIOD, SIM_PERIOD, SIM_PERIOD_TS);
  localparam int CNT_W   = $clog2(MAX_LEN);
  localparam logic [CNT_W-1:0] HW_LAST  = CNT_W'(HW_PERIOD - 1);
  localparam logic [CNT_W-1:0] HIGH_LIM = CNT_W'(HIGH_CYCLES);

  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] simLast;
  logic [CNT_W-1:0] activeLast;

  // The timestamp build fixes which shortened period applies.
  generate
    if (TS_BUILD != 0) begin : g_simTs
      assign simLast = CNT_W'(SIM_PERIOD_TS - 1);
    end else begin : g_simStd
      assign simLast = CNT_W'(SIM_PERIOD - 1);
    end
  endgenerate

  assign activeLast = simMode ? simLast : HW_LAST;
  // ">=" keeps a switch to a shorter period from overrunning.
  assign periodEnd  = (pos >= activeLast);
  assign inHigh     = (pos < HIGH_LIM);

  always_ff @(posedge clk) begin
    if (cmd.clear || cmd.load || cmd.wrap) pos <= '0;
    else if (cmd.advance)                  pos <= pos + 1'b1;
  end

endmodule

// File: rtl/amReqTimer.sv
module amReqTimer
  import amReqTimerPkg::*;
#(
  parameter int HW_PERIOD     = 81920,
  parameter int SIM_PERIOD    = 2552,
  parameter int SIM_PERIOD_TS = 5112,
  parameter int TS_BUILD      = 0,
  parameter int HIGH_CYCLES   = 4,
  parameter int FEC_ENABLE    = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic pllLocked,
  input  logic pcsReady,
  input  logic txValid,
  input  logic simMode,
  output logic amReq
);

  cntCmd_t cmd;
  logic    running;
  logic    periodEnd;
  logic    inHigh;

  amReqCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pllLocked (pllLocked),
    .pcsReady  (pcsReady),
    .txValid   (txValid),
    .periodEnd (periodEnd),
    .cmd       (cmd),
    .running   (running)
  );

  amReqCount #(
    .HW_PERIOD     (HW_PERIOD),
    .SIM_PERIOD    (SIM_PERIOD),
    .SIM_PERIOD_TS (SIM_PERIOD_TS),
    .TS_BUILD      (TS_BUILD),
    .HIGH_CYCLES   (HIGH_CYCLES)
  ) u_count (
    .clk       (clk),
    .cmd       (cmd),
    .simMode   (simMode),
    .periodEnd (periodEnd),
    .inHigh    (inHigh)
  );

  generate
    if (FEC_ENABLE != 0) begin : g_fec
      assign amReq = running & inHigh;
    end else begin : g_noFec
      assign amReq = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/amReqTimerChecker.sv
module amReqTimerChecker #(
  parameter int HIGH_CYCLES = 4
) (
  input logic clk,
  input logic rst,
  input logic pllLocked,
  input logic txValid,
  input logic amReq
);

  logic [15:0] hiRun;

  always_ff @(posedge clk) begin
    if (rst || !amReq)                hiRun <= '0;
    else if (txValid && hiRun != '1) hiRun <= hiRun + 1'b1;
  end

  // R5: a cycle without valid data leaves the request untouched
  a_r5_freeze: assert property (@(posedge clk) disable iff (rst)
    (!txValid && pllLocked) |=> $stable(amReq));

  // R1: loss of lock drops the request on the next cycle
  a_r1_lock_loss: assert property (@(posedge clk) disable iff (rst)
    !pllLocked |=> !amReq);

  // R2: a request can only rise after a locked cycle
  a_r2_rise_locked: assert property (@(posedge clk) disable iff (rst)
    $rose(amReq) |-> $past(pllLocked));

  // R5: a request can only rise after a valid cycle
  a_r5_rise_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(amReq) |-> $past(txValid));

  // R3: the request never spans more than the high time in valid cycles
  a_r3_high_bound: assert property (@(posedge clk) disable iff (rst)
    hiRun <= 16'(HIGH_CYCLES));

endmodule

bind amReqTimer amReqTimerChecker #(.HIGH_CYCLES(HIGH_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pllLocked (pllLocked),
  .txValid   (txValid),
  .amReq     (amReq)
);

// File: tb/amReqTimer_test.sv
module amReqTimer_test;

  localparam int HW    = 36;
  localparam int SIM   = 16;
  localparam int SIMTS = 24;
  localparam int HI    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pllLocked = 1'b0;
  logic pcsReady = 1'b0;
  logic txValid = 1'b0;
  logic simMode = 1'b0;
  logic amReq, amReqTs, amReqNoFec;

  always #5 clk = ~clk;

  amReqTimer #(.HW_PERIOD(HW), .SIM_PERIOD(SIM), .SIM_PERIOD_TS(SIMTS),
               .TS_BUILD(0), .HIGH_CYCLES(HI), .FEC_ENABLE(1)) uut (
    .clk(clk), .rst(rst), .pllLocked(pllLocked), .pcsReady(pcsReady),
    .txValid(txValid), .simMode(simMode), .amReq(amReq));

  amReqTimer #(.HW_PERIOD(HW), .SIM_PERIOD(SIM), .SIM_PERIOD_TS(SIMTS),
               .TS_BUILD(1), .HIGH_CYCLES(HI), .FEC_ENABLE(1)) uutTs (
    .clk(clk), .rst(rst), .pllLocked(pllLocked), .pcsReady(pcsReady),
    .txValid(txValid), .simMode(simMode), .amReq(amReqTs));

  amReqTimer #(.HW_PERIOD(HW), .SIM_PERIOD(SIM), .SIM_PERIOD_TS(SIMTS),
               .TS_BUILD(0), .HIGH_CYCLES(HI), .FEC_ENABLE(0)) uutNoFec (
    .clk(clk), .rst(rst), .pllLocked(pllLocked), .pcsReady(pcsReady),
    .txValid(txValid), .simMode(simMode), .amReq(amReqNoFec));

  int    vectors = 0;
  int    miscompares = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // behavioural reference state, one slot per FEC-enabled instance
  bit mArmed[2];
  bit mRun[2];
  int mPos[2];
  bit mPrevReady, mPrevLock, mPrevMode;
  bit prevOut[2], haveRise[2], trackHi[2];
  int gap[2], hiLen[2];

  function automatic int periodOf(int i, bit sm);
    if (!sm) return HW;
    return (i == 1) ? SIMTS : SIM;
  endfunction

  function automatic bit outOf(int i);
    return (i == 0) ? amReq : amReqTs;
  endfunction

  task automatic check(string req, int actual, int expected, string what);
    vectors++;
    if (actual != expected) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t",
               req, what, actual, expected, $time);
    end
  endtask

  task automatic modelEdge();
    bit edgeSeen, startOk;
    edgeSeen = pllLocked && mPrevLock && (pcsReady != mPrevReady);
    for (int i = 0; i < 2; i++) begin
      if (rst || !pllLocked || (simMode != mPrevMode)) begin
        haveRise[i] = 1'b0;
        trackHi[i]  = 1'b0;
      end else if (txValid) begin
        gap[i]++;
        if (prevOut[i]) hiLen[i]++;
      end
      if (rst || !pllLocked) begin
        mArmed[i] = 1'b0;
        mRun[i]   = 1'b0;
        mPos[i]   = 0;
      end else begin
        startOk = mArmed[i] || edgeSeen;
        if (edgeSeen) mArmed[i] = 1'b1;
        if (txValid) begin
          if (mRun[i]) mPos[i] = (mPos[i] >= periodOf(i, simMode) - 1) ? 0 : mPos[i] + 1;
          else if (startOk) begin
            mRun[i] = 1'b1;
            mPos[i] = 0;
          end
        end
      end
    end
    mPrevReady = rst ? 1'b0 : pcsReady;
    mPrevLock  = rst ? 1'b0 : pllLocked;
    mPrevMode  = simMode;
  endtask

  task automatic observe();
    bit o;
    for (int i = 0; i < 2; i++) begin
      o = outOf(i);
      check(curReq, o, (mRun[i] && mPos[i] < HI) ? 1 : 0,
            (i == 0) ? "amReq per-cycle" : "amReq ts-build per-cycle");
      if (o && !prevOut[i]) begin
        if (haveRise[i])
          check((i == 1) ? "R6" : "R4", gap[i], periodOf(i, simMode), "valid cycles between rises");
        haveRise[i] = 1'b1;
        trackHi[i]  = 1'b1;
        gap[i]      = 0;
        hiLen[i]    = 0;
      end
      if (!o && prevOut[i] && trackHi[i])
        check("R3", hiLen[i], HI, "valid cycles with request high");
      prevOut[i] = o;
    end
    check("R7", amReqNoFec, 0, "request with FEC disabled");
  endtask

  task automatic tick(bit r, bit lk, bit rd, bit v, bit sm);
    rst = r; pllLocked = lk; pcsReady = rd; txValid = v; simMode = sm;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    observe();
  endtask

  function automatic bit randValid(int pctHigh);
    return ($urandom_range(0, 99) < pctHigh);
  endfunction

  initial begin
    void'($urandom(7));
    // R1: reset state
    curReq = "R1";
    repeat (4) tick(1, 0, 0, 1, 1);
    // R2: ready activity without lock, then lock with a quiet ready
    curReq = "R2";
    for (int k = 0; k < 10; k++) tick(0, 0, k[0], 1, 1);
    repeat (12) tick(0, 1, 0, 1, 1);
    tick(0, 1, 1, 0, 1);
    // R8 and R3/R4: steady ready, unbroken valid stream
    curReq = "R8";
    repeat (90) tick(0, 1, 1, 1, 1);
    // R5: random valid-low gaps in the short period
    curReq = "R5";
    repeat (400) tick(0, 1, 1, randValid(65), 1);
    // R6: hardware period with gaps
    curReq = "R6";
    repeat (400) tick(0, 1, 1, randValid(75), 0);
    // R1: lock loss mid-period, relock with a quiet ready stays idle
    curReq = "R1";
    repeat (5) tick(0, 0, 1, 1, 1);
    repeat (15) tick(0, 1, 1, 1, 1);
    curReq = "R2";
    tick(0, 1, 0, 1, 1);
    curReq = "R5";
    for (int k = 0; k < 300; k++) tick(0, 1, 0, ((k % 37) > 24) ? 1'b0 : randValid(80), 1);
    // R1: synchronous reset mid-run, then restart
    curReq = "R1";
    repeat (3) tick(1, 1, 0, 1, 1);
    repeat (8) tick(0, 1, 0, 1, 1);
    curReq = "R4";
    tick(0, 1, 1, 1, 1);
    repeat (150) tick(0, 1, 1, randValid(50), 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule